// File: doc/BRIEF.md
# ISA Namespace Control Register

This block is a 32-bit control register that tells the core which instruction-set namespace is active. Its lowest bit chooses between the native architecture and a foreign one. In native mode each of the upper bits is an independent feature flag. In foreign mode the bits just above the selector form a 7-bit binary code that names exactly one foreign instruction set, and every bit above that code is reserved.

Software accesses the register through a plain write strobe with data and a combinational read. Every write is checked against the features the instance implements, which are given as parameters. A write that cannot be honoured exactly is never trimmed to fit. It raises a one-cycle trap and leaves the register as it was, so that software can take the trap and fall back to emulation. The decoded mode, the foreign code and the native flag vector go straight to the core.

Top module: `isa_space_reg`

## Requirements
- R1: After reset the read value is 0, foreign_o is 0, foreign_idx_o is 0 and native_flags_o is 0.
- R2: A write with bit 0 clear whose set bits all lie within the implemented native flags (default: bits 1 and 2) is stored on the next clock edge with no trap. native_flags_o then equals the read value's bits [31:1].
- R3: A write with bit 0 clear that sets any native flag not in the implemented mask pulses trap_o in the same cycle and leaves the stored value unchanged.
- R4: A write with bit 0 set, bits [7:1] holding a supported foreign code and bits [31:8] zero, is stored with no trap. foreign_o then reads 1, foreign_idx_o equals the code and native_flags_o is 0. The default supported codes are 8, 9 and 64.
- R5: A foreign write whose code is not supported traps and leaves the register unchanged.
- R6: A foreign write that sets any bit in [31:8] traps and leaves the register unchanged, even when its code is supported.
- R7: Writing zero never traps. It returns the register to native mode with all flags clear.
- R8: trap_o is asserted only in a cycle where wr_en_i is high. It is never asserted while no write is presented.
- R9: In native mode foreign_idx_o reads 0. In foreign mode native_flags_o reads 0.
- R10: Foreign codes 64 to 127 (top code bit set) are the custom range. They are legal only where the supported-code parameter enables them: by default code 64 is legal and code 65 traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Stored register value, combinational |
| trap_o | output | 1 | Illegal-write trap, same cycle as the write |
| foreign_o | output | 1 | Foreign namespace active |
| foreign_idx_o | output | 7 | Active foreign code, zero in native mode |
| native_flags_o | output | 31 | Native feature flags, zero in foreign mode |

## Verification
On every cycle, the assertions check three things: a trapping write leaves the stored value untouched, a legal write lands exactly, and no trap appears without a write strobe. They also check that the two decoded views exclude each other, with no flags in foreign mode, no code in native mode and the reserved foreign bits always zero. Whether a particular value is legal depends on the parameter tables. Only the bench's directed writes can show this: the edge flags, supported and unsupported codes, the custom range, and reserved bits combined with a valid code.

// File: rtl/isa_space_pkg.sv
package isa_space_pkg;
   typedef enum logic {
      NS_NATIVE  = 1'b0,
      NS_FOREIGN = 1'b1
   } ns_mode_e;

   localparam int unsigned SEL_BIT = 0;
endpackage

// File: rtl/isa_space_check.sv
module isa_space_check #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CODE_W = 7,
   parameter logic [DATA_W-2:0] NATIVE_MASK = '0,
   parameter logic [(1<<CODE_W)-1:0] FOREIGN_SUPPORT = '0
) (
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              legal_o
);
   import isa_space_pkg::*;

   localparam int unsigned FLAG_W = DATA_W - 1;
   localparam int unsigned RSV_LO = CODE_W + 1;

   logic [FLAG_W-1:0] flag_ok;
   logic              native_ok;
   logic              foreign_ok;
   logic              code_ok;
   logic              rsv_clear;
   ns_mode_e          req_mode;

   assign req_mode = ns_mode_e'(wr_data_i[SEL_BIT]);

   // each native flag is checked on its own, as if it were a separate register
   for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag
      if (NATIVE_MASK[gi]) begin : g_impl
         assign flag_ok[gi] = 1'b1;
      end else begin : g_absent
         assign flag_ok[gi] = ~wr_data_i[gi+1];
      end
   end
   assign native_ok = &flag_ok;

   // foreign lookup: a table with no entries collapses to constant refusal
   if (FOREIGN_SUPPORT == '0) begin : g_no_foreign
      assign code_ok = 1'b0;
   end else begin : g_foreign_tbl
      assign code_ok = FOREIGN_SUPPORT[wr_data_i[CODE_W:1]];
   end

   assign rsv_clear  = (wr_data_i[DATA_W-1:RSV_LO] == '0);
   assign foreign_ok = code_ok & rsv_clear;
   assign legal_o    = (req_mode == NS_FOREIGN) ? foreign_ok : native_ok;

   // R7: zero is always an acceptable value
   always_comb begin
      if (wr_data_i == '0) begin
         a_r7_zero_legal: assert (legal_o) else $error("zero write refused");
      end
   end
endmodule

// File: rtl/isa_space_store.sv
module isa_space_store #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (load_i) begin
         q_o <= d_i;
      end
   end

   a_r2_legal_lands: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (q_o == $past(d_i)))
      else $error("legal write not stored");
endmodule

// File: rtl/isa_space_decode.sv
module isa_space_decode #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CODE_W = 7
) (
   input  logic [DATA_W-1:0] q_i,
   output logic              foreign_o,
   output logic [CODE_W-1:0] idx_o,
   output logic [DATA_W-2:0] flags_o
);
   import isa_space_pkg::*;

   ns_mode_e mode;
   assign mode = ns_mode_e'(q_i[SEL_BIT]);

   always_comb begin
      foreign_o = 1'b0;
      idx_o     = '0;
      flags_o   = '0;
      case (mode)
         NS_FOREIGN: begin
            foreign_o = 1'b1;
            idx_o     = q_i[CODE_W:1];
         end
         default: begin
            flags_o = q_i[DATA_W-1:1];
         end
      endcase
   end
endmodule

// File: rtl/isa_space_reg.sv
module isa_space_reg #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CODE_W = 7,
   parameter logic [DATA_W-2:0] NATIVE_MASK = 31'h0000_0003,
   parameter logic [(1<<CODE_W)-1:0] FOREIGN_SUPPORT =
      (128'd1 << 8) | (128'd1 << 9) | (128'd1 << 64)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [31:0]       wr_data_i,
   output logic [31:0]       rd_data_o,
   output logic              trap_o,
   output logic              foreign_o,
   output logic [6:0]        foreign_idx_o,
   output logic [30:0]       native_flags_o
);
   initial begin
      a_cfg_width: assert (DATA_W == 32) else $error("DATA_W must be 32");
      a_cfg_code: assert (CODE_W == 7) else $error("CODE_W must be 7");
   end

   logic legal;
   logic load;

   isa_space_check #(
      .DATA_W(DATA_W), .CODE_W(CODE_W),
      .NATIVE_MASK(NATIVE_MASK), .FOREIGN_SUPPORT(FOREIGN_SUPPORT)
   ) u_check (
      .wr_data_i(wr_data_i),
      .legal_o  (legal)
   );

   assign load   = wr_en_i & legal;
   assign trap_o = wr_en_i & ~legal;

   isa_space_store #(.DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load),
      .d_i   (wr_data_i),
      .q_o   (rd_data_o)
   );

   isa_space_decode #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_decode (
      .q_i      (rd_data_o),
      .foreign_o(foreign_o),
      .idx_o    (foreign_idx_o),
      .flags_o  (native_flags_o)
   );

   a_r3_trap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |=> (rd_data_o == $past(rd_data_o)))
      else $error("trapping write changed register");

   a_r8_trap_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |-> !trap_o)
      else $error("trap without write");

   a_r9_views_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      foreign_o |-> (native_flags_o == '0))
      else $error("flags visible in foreign mode");

   a_r9_no_idx_native: assert property (@(posedge clk) disable iff (!rst_n)
      !foreign_o |-> (foreign_idx_o == '0))
      else $error("code visible in native mode");

   a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      foreign_o |-> (rd_data_o[31:8] == '0))
      else $error("reserved bits stored in foreign mode");
endmodule

// File: tb/isa_space_reg_bench.sv
`timescale 1ns/1ps
module isa_space_reg_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [31:0] wr_data_i = '0;
   logic [31:0] rd_data_o;
   logic        trap_o;
   logic        foreign_o;
   logic [6:0]  foreign_idx_o;
   logic [30:0] native_flags_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   isa_space_reg u_isa_space_reg (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .trap_o(trap_o), .foreign_o(foreign_o),
      .foreign_idx_o(foreign_idx_o), .native_flags_o(native_flags_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // present one write, check trap in that cycle, then the stored value after the edge
   task automatic do_write(input string tag, input logic [31:0] d,
                           input logic exp_trap, input logic [31:0] exp_rd);
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_data_i = d;
      #1;
      chk({tag, " trap"}, {31'd0, trap_o}, {31'd0, exp_trap});
      @(negedge clk);
      wr_en_i = 1'b0;
      #1;
      chk({tag, " value"}, rd_data_o, exp_rd);
      chk("R8 idle trap", {31'd0, trap_o}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R1 read", rd_data_o, 32'd0);
      chk("R1 foreign", {31'd0, foreign_o}, 32'd0);
      chk("R1 idx", {25'd0, foreign_idx_o}, 32'd0);
      chk("R1 flags", {1'b0, native_flags_o}, 32'd0);
   endtask

   task automatic t_native;
      do_write("R2 flags 1,2", 32'h0000_0006, 1'b0, 32'h0000_0006);
      chk("R2 flag view", {1'b0, native_flags_o}, 32'h0000_0003);
      chk("R9 idx zero native", {25'd0, foreign_idx_o}, 32'd0);
      do_write("R3 flag 3", 32'h0000_000E, 1'b1, 32'h0000_0006);
      do_write("R3 top flag", 32'h8000_0000, 1'b1, 32'h0000_0006);
      do_write("R2 flag 1 only", 32'h0000_0002, 1'b0, 32'h0000_0002);
   endtask

   task automatic t_foreign;
      do_write("R4 code 8", 32'h0000_0011, 1'b0, 32'h0000_0011);
      chk("R4 foreign", {31'd0, foreign_o}, 32'd1);
      chk("R4 idx", {25'd0, foreign_idx_o}, 32'd8);
      chk("R9 flags zero foreign", {1'b0, native_flags_o}, 32'd0);
      do_write("R4 code 9", 32'h0000_0013, 1'b0, 32'h0000_0013);
      chk("R4 idx 9", {25'd0, foreign_idx_o}, 32'd9);
      do_write("R5 code 10", 32'h0000_0015, 1'b1, 32'h0000_0013);
      do_write("R5 code 0", 32'h0000_0001, 1'b1, 32'h0000_0013);
      do_write("R6 code 8 + bit 8", 32'h0000_0111, 1'b1, 32'h0000_0013);
      do_write("R6 code 8 + bit 31", 32'h8000_0011, 1'b1, 32'h0000_0013);
      do_write("R10 code 64", 32'h0000_0081, 1'b0, 32'h0000_0081);
      chk("R10 idx 64", {25'd0, foreign_idx_o}, 32'd64);
      do_write("R10 code 65", 32'h0000_0083, 1'b1, 32'h0000_0081);
   endtask

   task automatic t_zero;
      do_write("R7 zero from foreign", 32'h0000_0000, 1'b0, 32'h0000_0000);
      chk("R7 native", {31'd0, foreign_o}, 32'd0);
      do_write("R2 flag 2", 32'h0000_0004, 1'b0, 32'h0000_0004);
      do_write("R7 zero from native", 32'h0000_0000, 1'b0, 32'h0000_0000);
   endtask

   task automatic t_idle;
      @(negedge clk);
      wr_data_i = 32'hFFFF_FFFF;
      #1;
      chk("R8 no strobe no trap", {31'd0, trap_o}, 32'd0);
      @(negedge clk);
      #1;
      chk("R8 no strobe no change", rd_data_o, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_native();
      t_foreign();
      t_zero();
      t_idle();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule